// File: doc/BRIEF.md
# Warp Issue Arbiter with Selectable Ordering

This block is one issue arbiter of a SIMT core. It watches a fixed group of warps and, each cycle, chooses at most one of them to hand an instruction to the execution back end. Several arbiters sit side by side in a core, and warps are spread across them by warp id modulo the arbiter count. With two arbiters, one takes the even warps and the other takes the odd warps, and both run at the same time. Each arbiter instance is told its own index and the arbiter count by parameters. Local slot k of an instance stands for global warp `SCHED_ID + k*NUM_SCHED`.

The front end reports the state of each warp's instruction buffer: whether an entry is held, its PC and op class, and the active lane mask. The warp's current PC, its waiting flag and its scoreboard verdict come in beside them. The back end reports whether its memory and arithmetic pipeline registers have a free entry, and whether it can take an instruction at all. A static configuration input picks the ordering. Loose round-robin starts the search after the last warp that issued. Greedy-then-oldest stays with the last issuer for as long as it can go, and otherwise takes the warp with the oldest launch stamp. A warp whose buffered PC no longer matches its current PC has its buffer flushed. Cycles with no issue are counted.

The issue decision is combinational from the status inputs and the internal state. The last-issued warp, the launch stamps and the stall count are registers.

Top module: `warp_issue_sched`

## Requirements
- R1: An issued instruction carries global warp id `SCHED_ID + slot*NUM_SCHED` on `issue_warp_id`, where slot is the local index of the chosen warp, and carries `SCHED_ID` on `issue_sched_id`.
- R2: A slot is eligible only when all of the following hold: its buffer entry is valid, it is not waiting, the buffered PC equals its current PC, and its scoreboard reports clear. The pipeline its op class targets must also have room: `ibuf_is_mem` bit 1 needs `mem_free`, and bit 0 needs `alu_free`.
- R3: In the same cycle, every slot that has a valid entry, is not waiting and has a PC mismatch raises its bit of `flush`, whatever `be_ready` is. Such a slot is never the one issued.
- R4: When `issue_valid` is high, `issue_mask`, `issue_pc` and `issue_is_mem` equal the chosen slot's active mask, buffered PC and op class.
- R5: With `policy_gto` = 0, the chosen slot is the first eligible slot found when scanning upward from the slot after the last issuer, wrapping past the top. After reset, the scan starts at slot 0.
- R6: With `policy_gto` = 1, once any warp has issued since reset, the last issuer is chosen again whenever it is eligible.
- R7: With `policy_gto` = 1, if the last issuer is not eligible (or none has issued yet), the eligible slot with the smallest launch stamp is chosen, and ties go to the lower slot. A pulse on `launch_en` gives slot `launch_slot` the current value of an AGE_W-bit launch counter, which then steps by one. Reset clears all stamps and the counter to 0.
- R8: While `be_ready` is 0, `issue_valid` stays 0 and the last-issuer record does not change.
- R9: `stall_count` resets to 0. It rises by one, wrapping modulo 2^CNT_W, after each clock edge at which `issue_valid` was 0, and it holds its value after an edge at which an instruction issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_gto | input | 1 | Static ordering select: 0 loose round-robin, 1 greedy-then-oldest |
| ibuf_valid | input | WARPS | Per slot: buffer holds an instruction |
| ibuf_is_mem | input | WARPS | Per slot: op class, 1 memory, 0 arithmetic |
| ibuf_pc | input | WARPS*PC_W | Per slot: PC of the buffered instruction |
| warp_pc | input | WARPS*PC_W | Per slot: the warp's current PC |
| warp_waiting | input | WARPS | Per slot: warp is waiting |
| sb_clear | input | WARPS | Per slot: scoreboard reports no hazard |
| warp_amask | input | WARPS*LANES | Per slot: active lane mask |
| mem_free | input | 1 | Memory pipeline register has a free entry |
| alu_free | input | 1 | Arithmetic pipeline register has a free entry |
| be_ready | input | 1 | Back end can accept an instruction |
| launch_en | input | 1 | A warp is launched into slot `launch_slot` |
| launch_slot | input | SLOT_W | Local slot receiving the launch stamp |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_warp_id | output | GID_W | Global id of the issuing warp |
| issue_sched_id | output | SID_W | Index of this arbiter |
| issue_mask | output | LANES | Active lane mask of the issue |
| issue_pc | output | PC_W | PC of the issued instruction |
| issue_is_mem | output | 1 | Op class of the issued instruction |
| flush | output | WARPS | Per slot: drop the buffered instruction |
| stall_count | output | CNT_W | Cycles with no issue, wrapping |

## Verification
A flush and an issue can happen in the same cycle. One slot is dropped for a PC mismatch, while a different slot wins the arbitration, and the mismatching slot may sit ahead of the winner in priority order. Random stimulus makes this pairing frequent by forcing PC mismatches on some slots while others stay fully eligible. Each cycle, the bench compares the whole flush vector and the chosen warp id against its own model of the priority order. One directed case holds `be_ready` low with a mismatching slot present. It confirms that the flush still happens while nothing issues and while the stall count advances through its wrap.

// File: rtl/ws_pkg.sv
package ws_pkg;
   typedef enum logic {
      POL_LRR = 1'b0,
      POL_GTO = 1'b1
   } ws_policy_e;

   function automatic int ws_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ws_elig.sv
module ws_elig #(
   parameter int WARPS = 24,
   parameter int PC_W  = 32
) (
   input  logic [WARPS-1:0]      ibuf_valid,
   input  logic [WARPS-1:0]      ibuf_is_mem,
   input  logic [WARPS*PC_W-1:0] ibuf_pc,
   input  logic [WARPS*PC_W-1:0] warp_pc,
   input  logic [WARPS-1:0]      warp_waiting,
   input  logic [WARPS-1:0]      sb_clear,
   input  logic                  mem_free,
   input  logic                  alu_free,
   output logic [WARPS-1:0]      elig,
   output logic [WARPS-1:0]      flush
);
   for (genvar w = 0; w < WARPS; w++) begin : g_slot
      logic live, pc_hit, pipe_ok;
      assign live    = ibuf_valid[w] & ~warp_waiting[w];
      assign pc_hit  = (ibuf_pc[w*PC_W +: PC_W] == warp_pc[w*PC_W +: PC_W]);
      assign pipe_ok = ibuf_is_mem[w] ? mem_free : alu_free;
      assign elig[w]  = live & pc_hit & sb_clear[w] & pipe_ok;
      assign flush[w] = live & ~pc_hit;
   end
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
   parameter int WARPS  = 24,
   parameter int SLOT_W = 5
) (
   input  logic [WARPS-1:0]  req,
   input  logic [SLOT_W-1:0] start,
   output logic              found,
   output logic [SLOT_W-1:0] slot
);
   always_comb begin
      int idx;
      found = 1'b0;
      slot  = '0;
      for (int k = 0; k < WARPS; k++) begin
         idx = int'(start) + k;
         if (idx >= WARPS) idx = idx - WARPS;
         if (!found && req[idx]) begin
            found = 1'b1;
            slot  = SLOT_W'(idx);
         end
      end
   end
endmodule

// File: rtl/ws_age_pick.sv
module ws_age_pick #(
   parameter int WARPS  = 24,
   parameter int SLOT_W = 5,
   parameter int AGE_W  = 8
) (
   input  logic [WARPS-1:0]       req,
   input  logic [WARPS*AGE_W-1:0] ages,
   output logic                   found,
   output logic [SLOT_W-1:0]      slot
);
   logic [AGE_W-1:0] best;

   always_comb begin
      found = 1'b0;
      slot  = '0;
      best  = '0;
      for (int i = 0; i < WARPS; i++) begin
         if (req[i] && (!found || ages[i*AGE_W +: AGE_W] < best)) begin
            found = 1'b1;
            slot  = SLOT_W'(i);
            best  = ages[i*AGE_W +: AGE_W];
         end
      end
   end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import ws_pkg::*;
#(
   parameter int WARPS     = 24,
   parameter int NUM_SCHED = 2,
   parameter int SCHED_ID  = 0,
   parameter int PC_W      = 32,
   parameter int LANES     = 32,
   parameter int AGE_W     = 8,
   parameter int CNT_W     = 16,
   localparam int SLOT_W   = ws_bits(WARPS),
   localparam int GID_W    = ws_bits(WARPS * NUM_SCHED),
   localparam int SID_W    = ws_bits(NUM_SCHED)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   policy_gto,
   input  logic [WARPS-1:0]       ibuf_valid,
   input  logic [WARPS-1:0]       ibuf_is_mem,
   input  logic [WARPS*PC_W-1:0]  ibuf_pc,
   input  logic [WARPS*PC_W-1:0]  warp_pc,
   input  logic [WARPS-1:0]       warp_waiting,
   input  logic [WARPS-1:0]       sb_clear,
   input  logic [WARPS*LANES-1:0] warp_amask,
   input  logic                   mem_free,
   input  logic                   alu_free,
   input  logic                   be_ready,
   input  logic                   launch_en,
   input  logic [SLOT_W-1:0]      launch_slot,
   output logic                   issue_valid,
   output logic [GID_W-1:0]       issue_warp_id,
   output logic [SID_W-1:0]       issue_sched_id,
   output logic [LANES-1:0]       issue_mask,
   output logic [PC_W-1:0]        issue_pc,
   output logic                   issue_is_mem,
   output logic [WARPS-1:0]       flush,
   output logic [CNT_W-1:0]       stall_count
);
   // elaboration-time parameter checks
   if (WARPS < 2) begin : g_chk_warps
      $error("warp_issue_sched: WARPS must be at least 2");
   end
   if (NUM_SCHED < 1) begin : g_chk_nsched
      $error("warp_issue_sched: NUM_SCHED must be at least 1");
   end
   if (SCHED_ID < 0 || SCHED_ID >= NUM_SCHED) begin : g_chk_sid
      $error("warp_issue_sched: SCHED_ID out of range");
   end
   if (AGE_W < 1 || CNT_W < 1) begin : g_chk_cnt
      $error("warp_issue_sched: counter widths must be positive");
   end

   ws_policy_e policy;
   assign policy = ws_policy_e'(policy_gto);

   logic [WARPS-1:0]       elig;
   logic [SLOT_W-1:0]      last_slot;
   logic                   last_vld;
   logic [WARPS*AGE_W-1:0] age_q;
   logic [AGE_W-1:0]       launch_cnt;
   logic [CNT_W-1:0]       stall_q;
   logic [SLOT_W-1:0]      rr_start, rr_slot, age_slot, sel;
   logic                   rr_found, age_found, any_found, greedy;

   ws_elig #(.WARPS(WARPS), .PC_W(PC_W)) u_elig (
      .ibuf_valid   (ibuf_valid),
      .ibuf_is_mem  (ibuf_is_mem),
      .ibuf_pc      (ibuf_pc),
      .warp_pc      (warp_pc),
      .warp_waiting (warp_waiting),
      .sb_clear     (sb_clear),
      .mem_free     (mem_free),
      .alu_free     (alu_free),
      .elig         (elig),
      .flush        (flush)
   );

   assign rr_start = (int'(last_slot) >= WARPS - 1) ? '0 : last_slot + 1'b1;

   ws_rr_pick #(.WARPS(WARPS), .SLOT_W(SLOT_W)) u_rr (
      .req   (elig),
      .start (rr_start),
      .found (rr_found),
      .slot  (rr_slot)
   );

   ws_age_pick #(.WARPS(WARPS), .SLOT_W(SLOT_W), .AGE_W(AGE_W)) u_age (
      .req   (elig),
      .ages  (age_q),
      .found (age_found),
      .slot  (age_slot)
   );

   assign greedy = last_vld & elig[last_slot];

   always_comb begin
      if (policy == POL_GTO) begin
         any_found = greedy | age_found;
         sel       = greedy ? last_slot : age_slot;
      end else begin
         any_found = rr_found;
         sel       = rr_slot;
      end
   end

   assign issue_valid    = be_ready & any_found;
   assign issue_warp_id  = GID_W'(SCHED_ID + int'(sel) * NUM_SCHED);
   assign issue_sched_id = SID_W'(SCHED_ID);
   assign issue_mask     = warp_amask[sel*LANES +: LANES];
   assign issue_pc       = ibuf_pc[sel*PC_W +: PC_W];
   assign issue_is_mem   = ibuf_is_mem[sel];
   assign stall_count    = stall_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_slot <= SLOT_W'(WARPS - 1);
         last_vld  <= 1'b0;
         stall_q   <= '0;
      end else if (issue_valid) begin
         last_slot <= sel;
         last_vld  <= 1'b1;
      end else begin
         stall_q   <= stall_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_q      <= '0;
         launch_cnt <= '0;
      end else if (launch_en && int'(launch_slot) < WARPS) begin
         age_q[launch_slot*AGE_W +: AGE_W] <= launch_cnt;
         launch_cnt <= launch_cnt + 1'b1;
      end
   end

   // R2
   issued_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (ibuf_valid[sel] && !warp_waiting[sel] && sb_clear[sel]));
   // R3
   no_flush_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !flush[sel]);
   // R5
   lrr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!policy_gto && issue_valid && elig[rr_start]) |-> sel == rr_start);
   // R6
   gto_greedy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_gto && be_ready && last_vld && elig[last_slot]) |-> (issue_valid && sel == last_slot));
   // R8
   be_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !be_ready |-> !issue_valid);
   // R8
   last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> $stable(last_slot));
   // R9
   stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> stall_count == CNT_W'($past(stall_count) + 1'b1));
   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |=> $stable(stall_count));
endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 6;
   localparam int NS    = 2;
   localparam int SID   = 1;
   localparam int PC_W  = 8;
   localparam int LANES = 8;
   localparam int AGE_W = 8;
   localparam int CNT_W = 8;
   localparam int SW    = 3;

   logic clk = 1'b0;
   logic rst_n;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic gto, mf, af, br, len;
   logic [SW-1:0] lslot;
   logic v[W], mem[W], wt[W], sb[W];
   logic [PC_W-1:0] ipc[W], wpc[W];
   logic [LANES-1:0] am[W];

   logic [W-1:0] v_f, mem_f, wt_f, sb_f;
   logic [W*PC_W-1:0] ipc_f, wpc_f;
   logic [W*LANES-1:0] am_f;
   always_comb begin
      for (int i = 0; i < W; i++) begin
         v_f[i] = v[i]; mem_f[i] = mem[i]; wt_f[i] = wt[i]; sb_f[i] = sb[i];
         ipc_f[i*PC_W +: PC_W] = ipc[i];
         wpc_f[i*PC_W +: PC_W] = wpc[i];
         am_f[i*LANES +: LANES] = am[i];
      end
   end

   logic iv, imem;
   logic [3:0] iwid;
   logic [0:0] isid;
   logic [LANES-1:0] imask;
   logic [PC_W-1:0] ipco;
   logic [W-1:0] fl;
   logic [CNT_W-1:0] scnt;

   warp_issue_sched #(.WARPS(W), .NUM_SCHED(NS), .SCHED_ID(SID), .PC_W(PC_W),
                      .LANES(LANES), .AGE_W(AGE_W), .CNT_W(CNT_W)) i_warp_issue_sched (
      .clk(clk), .rst_n(rst_n), .policy_gto(gto),
      .ibuf_valid(v_f), .ibuf_is_mem(mem_f), .ibuf_pc(ipc_f), .warp_pc(wpc_f),
      .warp_waiting(wt_f), .sb_clear(sb_f), .warp_amask(am_f),
      .mem_free(mf), .alu_free(af), .be_ready(br),
      .launch_en(len), .launch_slot(lslot),
      .issue_valid(iv), .issue_warp_id(iwid), .issue_sched_id(isid),
      .issue_mask(imask), .issue_pc(ipco), .issue_is_mem(imem),
      .flush(fl), .stall_count(scnt));

   int checks = 0, errors = 0;
   int m_last, m_lvld;
   logic [AGE_W-1:0] m_age[W];
   logic [AGE_W-1:0] m_lcnt;
   logic [CNT_W-1:0] m_stall;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit e_elig(input int i);
      return v[i] && !wt[i] && ipc[i] == wpc[i] && sb[i] && (mem[i] ? mf : af);
   endfunction

   function automatic bit e_flush(input int i);
      return v[i] && !wt[i] && ipc[i] != wpc[i];
   endfunction

   // returns chosen slot or -1
   function automatic int e_pick();
      int best = -1;
      if (gto) begin
         if (m_lvld != 0 && e_elig(m_last)) return m_last;
         for (int i = 0; i < W; i++)
            if (e_elig(i) && (best < 0 || m_age[i] < m_age[best])) best = i;
         return best;
      end
      for (int k = 0; k < W; k++) begin
         int idx = (m_last + 1 + k) % W;
         if (e_elig(idx)) return idx;
      end
      return -1;
   endfunction

   task automatic model_reset();
      m_last = W - 1; m_lvld = 0; m_lcnt = '0; m_stall = '0;
      for (int i = 0; i < W; i++) m_age[i] = '0;
   endtask

   // called just after a negedge with inputs settled
   task automatic cycle_check();
      int p;
      bit ev;
      logic [W-1:0] ef;
      string tag;
      #(CLK_PERIOD/4);
      p  = e_pick();
      ev = br && (p >= 0);
      for (int i = 0; i < W; i++) ef[i] = e_flush(i);
      chk(iv == ev, br ? "R2" : "R8", iv, ev);
      chk(fl == ef, "R3", fl, ef);
      chk(scnt == m_stall, "R9", scnt, m_stall);
      if (ev && iv) begin
         tag = gto ? ((m_lvld != 0 && p == m_last) ? "R6" : "R7") : "R5";
         chk(iwid == 4'(SID + p*NS), tag, iwid, SID + p*NS);
         chk(isid == 1'(SID), "R1", isid, SID);
         chk(imask == am[p], "R4", imask, am[p]);
         chk(ipco == ipc[p] && imem == mem[p], "R4", {ipco, imem}, {ipc[p], mem[p]});
      end
      @(posedge clk);
      if (len && int'(lslot) < W) begin
         m_age[lslot] = m_lcnt;
         m_lcnt = m_lcnt + 1'b1;
      end
      if (ev) begin m_last = p; m_lvld = 1; end
      else m_stall = m_stall + 1'b1;
      @(negedge clk);
   endtask

   task automatic all_ready();
      mf = 1; af = 1; br = 1; len = 0; lslot = '0;
      for (int i = 0; i < W; i++) begin
         v[i] = 1; mem[i] = i[0]; wt[i] = 0; sb[i] = 1;
         ipc[i] = PC_W'(8'h10 + i); wpc[i] = ipc[i]; am[i] = LANES'(8'h81 ^ i);
      end
   endtask

   task automatic rand_inputs();
      mf = ($urandom % 10) < 7; af = ($urandom % 10) < 7;
      br = ($urandom % 100) < 85;
      len = ($urandom % 8) == 0; lslot = SW'($urandom % W);
      for (int i = 0; i < W; i++) begin
         v[i]  = ($urandom % 10) < 8;
         mem[i] = $urandom % 2;
         wt[i] = ($urandom % 100) < 15;
         sb[i] = ($urandom % 4) != 0;
         wpc[i] = PC_W'($urandom);
         ipc[i] = (($urandom % 100) < 15) ? wpc[i] ^ PC_W'(1 + $urandom % 255) : wpc[i];
         am[i] = LANES'($urandom);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      model_reset();
      // R9 reset value
      chk(scnt == '0, "R9", scnt, 0);
      rst_n = 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      gto = 0;
      all_ready();
      do_reset();
      // R5: round-robin from slot 0 with wrap
      for (int n = 0; n < 9; n++) cycle_check();
      // R8/R9/R3: back end full, one PC mismatch, counter wraps
      br = 0; wpc[2] = wpc[2] + 1'b1;
      for (int n = 0; n < 260; n++) cycle_check();
      br = 1;
      for (int n = 0; n < 4; n++) cycle_check();
      // R2: pipeline free gating
      all_ready(); mf = 0;
      for (int n = 0; n < 4; n++) cycle_check();
      for (int n = 0; n < 1500; n++) begin rand_inputs(); cycle_check(); end

      gto = 1;
      all_ready();
      do_reset();
      // R7: launch stamps out of order, nothing eligible
      for (int i = 0; i < W; i++) v[i] = 0;
      len = 1;
      foreach (m_age[k]) begin
         lslot = SW'((3 + 4*k) % W);
         cycle_check();
      end
      all_ready();
      // R7 then R6: oldest first, then greedy
      for (int n = 0; n < 4; n++) cycle_check();
      wt[3] = 1;
      for (int n = 0; n < 4; n++) cycle_check();
      for (int n = 0; n < 1500; n++) begin rand_inputs(); cycle_check(); end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule